// File: doc/BRIEF.md
# USB Endpoint Status Register Bank

This block keeps the per-endpoint status that a USB serial interface engine and an 8-bit processor share. There are five endpoints; endpoint 0 is the control endpoint. Each endpoint owns two registers. A counter register holds a 6-bit byte count, a data-valid flag and the DATA0/DATA1 toggle. A mode register holds a 4-bit response mode, an ACK flag and a STALL bit. One shared pending register collects a sticky interrupt bit per endpoint.

The serial engine reports each finished transaction as a one-cycle event. The event carries the endpoint number, the token kind, the received count (data bytes plus the two CRC bytes), the CRC verdict, the received toggle and whether the handshake was ACK. The processor reads and writes registers through a small port that has a write strobe, a read strobe and a combinational read-data bus. The endpoint-0 counter is write-protected from each SETUP/OUT update until the processor has read it, so firmware cannot overwrite a fresh receive status before it has seen it.

Top module: `usb_ep_regbank`

## Requirements
- R1: The address map is fixed. Addresses 0..4 are the counter registers of endpoints 0..4, with the count in bits 5..0, data valid in bit 6 and toggle in bit 7. Addresses 8..12 are the mode registers, with the mode in bits 3..0, ACK in bit 4, reserved bits 6..5 that read 0, and STALL in bit 7. Address 15 is the pending register, with endpoint i in bit i. Every other address reads 0. All registers are 0 after reset.
- R2: An event with token OUT (code 0) or SETUP (code 2) loads that endpoint's counter on the next clock: the count, data valid equal to the CRC verdict, and the received toggle. An IN (code 1) or code 3 event leaves the counter unchanged.
- R3: A received count above 34 is stored as 34. An accepted processor counter write with a count above 32 is stored as 32. Either case drives `cnt_err` high for exactly the following cycle.
- R4: A processor write to a counter register loads the count, data valid and toggle from `cpu_wdata` on the next clock.
- R5: An OUT/SETUP update of endpoint 0 locks its counter. Processor writes to address 0 are then ignored until a cycle with `cpu_rd` high at address 0 removes the lock. If that read coincides with a new endpoint-0 OUT/SETUP update, the lock stays. Endpoints 1..4 never lock.
- R6: When an event updates a register in the same cycle as a processor write to it, the event wins and the write is dropped. This covers the counter on OUT/SETUP and the mode register when ACK is set.
- R7: An event with `sie_ack` high sets the endpoint's ACK bit. A processor write to a mode register stores bits 7, 4 and 3..0 and discards bits 6..5.
- R8: Every event to endpoint 0..4 sets that endpoint's pending bit, whatever the token or CRC. Writing 1 to a bit of address 15 clears it, and a same-cycle set wins. `ep_irq` shows the pending register.
- R9: `ep_stall_out[i]` is high when STALL is set and the mode is 4'hD (ACK-IN). `ep_stall_in[i]` is high when STALL is set and the mode is 4'h9 (ACK-OUT). Both follow the registers with no added delay.
- R10: Events that name endpoint 5 or above change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe (removes the endpoint-0 lock) |
| cpu_addr | input | 4 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr`, combinational |
| sie_evt | input | 1 | Transaction-complete event |
| sie_ep | input | 3 | Endpoint number of the event |
| sie_tok | input | 2 | Token: 0 OUT, 1 IN, 2 SETUP |
| sie_cnt | input | 7 | Received bytes including CRC |
| sie_crc_ok | input | 1 | CRC of the data packet was good |
| sie_tog | input | 1 | Received toggle, 1 for DATA1 |
| sie_ack | input | 1 | Transaction ended with ACK |
| ep_irq | output | 5 | Pending interrupt per endpoint |
| ep_stall_out | output | 5 | Answer OUT with STALL |
| ep_stall_in | output | 5 | Answer IN with STALL |
| cnt_err | output | 1 | Out-of-range count was saturated |

## Verification
Directed sequences separate the receive path from the processor path. A good-CRC OUT is followed by a bad-CRC SETUP with an oversized count, which tells data valid apart from the interrupt and shows saturation. Collisions in one cycle (event against write, unlock read against a new update, pending clear against a new set) tell the priority rules apart. Writes to endpoint 3 after its own update tell the endpoint-0-only lock apart from a global one. A long random mix of strobes, addresses, endpoints up to 6 and all four token codes is then compared against a behavioural model on every clock.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

    localparam int CNT_W     = 6;
    localparam int ADDR_W    = 4;
    localparam int MODE_BASE = 8;
    localparam int PEND_ADDR = 15;

    typedef enum logic [1:0] {
        TOK_OUT   = 2'd0,
        TOK_IN    = 2'd1,
        TOK_SETUP = 2'd2,
        TOK_RSVD  = 2'd3
    } tok_e;

    localparam logic [3:0] MODE_ACK_IN  = 4'hD;
    localparam logic [3:0] MODE_ACK_OUT = 4'h9;

    typedef struct packed {
        logic             tog;
        logic             dv;
        logic [CNT_W-1:0] cnt;
    } cnt_reg_t;

    typedef struct packed {
        logic       stall;
        logic       ack;
        logic [3:0] mode;
    } mode_reg_t;

endpackage

// File: rtl/usb_ep_cnt_next.sv
module usb_ep_cnt_next
    import usb_ep_pkg::*;
#(
    parameter int SIE_CW  = 7,
    parameter int OUT_MAX = 34,
    parameter int IN_MAX  = 32
) (
    input  cnt_reg_t          cur,
    input  logic              sie_hit,
    input  logic [SIE_CW-1:0] sie_cnt,
    input  logic              sie_crc_ok,
    input  logic              sie_tog,
    input  logic              cpu_hit,
    input  logic              wr_block,
    input  logic [7:0]        wdata,
    output cnt_reg_t          nxt,
    output logic              err
);
    logic sie_over;
    logic cpu_over;

    assign sie_over = sie_cnt > SIE_CW'(OUT_MAX);
    assign cpu_over = wdata[CNT_W-1:0] > CNT_W'(IN_MAX);

    always_comb begin
        nxt = cur;
        err = 1'b0;
        if (sie_hit) begin
            nxt.cnt = sie_over ? CNT_W'(OUT_MAX) : sie_cnt[CNT_W-1:0];
            nxt.dv  = sie_crc_ok;
            nxt.tog = sie_tog;
            err     = sie_over;
        end else if (cpu_hit && !wr_block) begin
            nxt.cnt = cpu_over ? CNT_W'(IN_MAX) : wdata[CNT_W-1:0];
            nxt.dv  = wdata[CNT_W];
            nxt.tog = wdata[CNT_W+1];
            err     = cpu_over;
        end
    end
endmodule

// File: rtl/usb_ep_mode_next.sv
module usb_ep_mode_next
    import usb_ep_pkg::*;
(
    input  mode_reg_t  cur,
    input  logic       ack_hit,
    input  logic       cpu_hit,
    input  logic [5:0] wbits,
    output mode_reg_t  nxt,
    output logic       stall_out,
    output logic       stall_in
);
    always_comb begin
        nxt = cur;
        if (ack_hit) begin
            nxt.ack = 1'b1;
        end else if (cpu_hit) begin
            nxt = wbits;
        end
    end

    assign stall_out = cur.stall && (cur.mode == MODE_ACK_IN);
    assign stall_in  = cur.stall && (cur.mode == MODE_ACK_OUT);
endmodule

// File: rtl/usb_ep_regbank.sv
module usb_ep_regbank
    import usb_ep_pkg::*;
#(
    parameter int NUM_EP  = 5,
    parameter int EP_W    = 3,
    parameter int SIE_CW  = 7,
    parameter int OUT_MAX = 34,
    parameter int IN_MAX  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [3:0]        cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              sie_evt,
    input  logic [EP_W-1:0]   sie_ep,
    input  logic [1:0]        sie_tok,
    input  logic [SIE_CW-1:0] sie_cnt,
    input  logic              sie_crc_ok,
    input  logic              sie_tog,
    input  logic              sie_ack,
    output logic [NUM_EP-1:0] ep_irq,
    output logic [NUM_EP-1:0] ep_stall_out,
    output logic [NUM_EP-1:0] ep_stall_in,
    output logic              cnt_err
);
    localparam logic [EP_W:0] NUM_EP_L = (EP_W+1)'(NUM_EP);

    typedef struct packed {
        cnt_reg_t  [NUM_EP-1:0] cnt;
        mode_reg_t [NUM_EP-1:0] mode;
        logic      [NUM_EP-1:0] pend;
        logic                   lock0;
        logic                   err;
    } state_t;

    state_t st_q, st_d;

    logic                   ev_valid;
    logic                   cnt_upd;
    logic [NUM_EP-1:0]      ep_sel;
    logic [NUM_EP-1:0]      err_vec;
    cnt_reg_t  [NUM_EP-1:0] cnt_nxt;
    mode_reg_t [NUM_EP-1:0] mode_nxt;
    logic                   rd_ep0;
    logic                   wr_pend;

    assign ev_valid = sie_evt && ({1'b0, sie_ep} < NUM_EP_L);
    assign cnt_upd  = ev_valid && ((tok_e'(sie_tok) == TOK_OUT) ||
                                   (tok_e'(sie_tok) == TOK_SETUP));
    assign rd_ep0   = cpu_rd && (cpu_addr == '0);
    assign wr_pend  = cpu_wr && (cpu_addr == ADDR_W'(PEND_ADDR));

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic cpu_cnt_hit;
        logic cpu_mode_hit;

        assign ep_sel[i]    = ev_valid && (sie_ep == EP_W'(i));
        assign cpu_cnt_hit  = cpu_wr && (cpu_addr == ADDR_W'(i));
        assign cpu_mode_hit = cpu_wr && (cpu_addr == ADDR_W'(MODE_BASE + i));

        usb_ep_cnt_next #(
            .SIE_CW  (SIE_CW),
            .OUT_MAX (OUT_MAX),
            .IN_MAX  (IN_MAX)
        ) u_cnt (
            .cur        (st_q.cnt[i]),
            .sie_hit    (ep_sel[i] && cnt_upd),
            .sie_cnt    (sie_cnt),
            .sie_crc_ok (sie_crc_ok),
            .sie_tog    (sie_tog),
            .cpu_hit    (cpu_cnt_hit),
            .wr_block   ((i == 0) ? st_q.lock0 : 1'b0),
            .wdata      (cpu_wdata),
            .nxt        (cnt_nxt[i]),
            .err        (err_vec[i])
        );

        usb_ep_mode_next u_mode (
            .cur       (st_q.mode[i]),
            .ack_hit   (ep_sel[i] && sie_ack),
            .cpu_hit   (cpu_mode_hit),
            .wbits     ({cpu_wdata[7], cpu_wdata[4:0]}),
            .nxt       (mode_nxt[i]),
            .stall_out (ep_stall_out[i]),
            .stall_in  (ep_stall_in[i])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = cnt_nxt;
        st_d.mode = mode_nxt;
        st_d.err  = |err_vec;
        st_d.pend = (st_q.pend & ~(wr_pend ? cpu_wdata[NUM_EP-1:0] : '0)) | ep_sel;
        if (ep_sel[0] && cnt_upd) begin
            st_d.lock0 = 1'b1;
        end else if (rd_ep0) begin
            st_d.lock0 = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cpu_rdata = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (cpu_addr == ADDR_W'(i)) begin
                cpu_rdata = st_q.cnt[i];
            end
            if (cpu_addr == ADDR_W'(MODE_BASE + i)) begin
                cpu_rdata = {st_q.mode[i].stall, 2'b00, st_q.mode[i].ack, st_q.mode[i].mode};
            end
        end
        if (cpu_addr == ADDR_W'(PEND_ADDR)) begin
            cpu_rdata = 8'(st_q.pend);
        end
    end

    assign ep_irq  = st_q.pend;
    assign cnt_err = st_q.err;
endmodule

// File: rtl/usb_ep_regbank_chk.sv
module usb_ep_regbank_chk #(
    parameter int NUM_EP  = 5,
    parameter int EP_W    = 3,
    parameter int OUT_MAX = 34
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cpu_wr,
    input logic [3:0]             cpu_addr,
    input logic [7:0]             cpu_rdata,
    input logic                   sie_evt,
    input logic [EP_W-1:0]        sie_ep,
    input logic [1:0]             sie_tok,
    input logic                   sie_crc_ok,
    input logic                   sie_ack,
    input logic [NUM_EP-1:0]      ep_irq,
    input logic [NUM_EP-1:0][7:0] cnt_regs,
    input logic [NUM_EP-1:0][5:0] mode_regs,
    input logic                   lock0
);
    logic ev_ok;
    logic rx_upd;
    assign ev_ok  = sie_evt && ({1'b0, sie_ep} < (EP_W+1)'(NUM_EP));
    assign rx_upd = ev_ok && (sie_tok == 2'd0 || sie_tok == 2'd2);

    p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ok |=> ep_irq[$past(sie_ep)]);

    p_dv_follows_crc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_upd |=> (cnt_regs[$past(sie_ep)][6] == $past(sie_crc_ok)));

    p_lock_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_upd && sie_ep == '0) |=> lock0);

    p_locked_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock0 && cpu_wr && cpu_addr == 4'd0 && !(rx_upd && sie_ep == '0))
        |=> $stable(cnt_regs[0]));

    p_ack_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ok && sie_ack) |=> mode_regs[$past(sie_ep)][4]);

    p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= 4'd8 && cpu_addr < 4'(8 + NUM_EP)) |-> (cpu_rdata[6:5] == 2'b00));

    for (genvar g = 0; g < NUM_EP; g++) begin : g_rng
        p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_regs[g][5:0] <= 6'(OUT_MAX));
    end
endmodule

bind usb_ep_regbank usb_ep_regbank_chk #(
    .NUM_EP  (NUM_EP),
    .EP_W    (EP_W),
    .OUT_MAX (OUT_MAX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_wr     (cpu_wr),
    .cpu_addr   (cpu_addr),
    .cpu_rdata  (cpu_rdata),
    .sie_evt    (sie_evt),
    .sie_ep     (sie_ep),
    .sie_tok    (sie_tok),
    .sie_crc_ok (sie_crc_ok),
    .sie_ack    (sie_ack),
    .ep_irq     (ep_irq),
    .cnt_regs   (st_q.cnt),
    .mode_regs  (st_q.mode),
    .lock0      (st_q.lock0)
);

// File: tb/usb_ep_regbank_tb.sv
`timescale 1ns/1ps
module usb_ep_regbank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 0, cpu_rd = 0;
    logic [3:0] cpu_addr = 0;
    logic [7:0] cpu_wdata = 0;
    logic [7:0] cpu_rdata;
    logic       sie_evt = 0;
    logic [2:0] sie_ep = 0;
    logic [1:0] sie_tok = 0;
    logic [6:0] sie_cnt = 0;
    logic       sie_crc_ok = 0, sie_tog = 0, sie_ack = 0;
    logic [4:0] ep_irq, ep_stall_out, ep_stall_in;
    logic       cnt_err;

    always #2 clk = ~clk;

    usb_ep_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .sie_evt(sie_evt), .sie_ep(sie_ep), .sie_tok(sie_tok), .sie_cnt(sie_cnt),
        .sie_crc_ok(sie_crc_ok), .sie_tog(sie_tog), .sie_ack(sie_ack),
        .ep_irq(ep_irq), .ep_stall_out(ep_stall_out), .ep_stall_in(ep_stall_in),
        .cnt_err(cnt_err)
    );

    // behavioural reference state
    int m_cnt[5], m_dv[5], m_tog[5], m_mode[5], m_ack[5], m_stall[5];
    int m_pend, m_lock, m_err;
    int n_vec = 0, n_bad = 0;
    bit done = 0;

    function automatic int m_read(int a);
        if (a < 5) return m_tog[a] * 128 + m_dv[a] * 64 + m_cnt[a];
        if (a >= 8 && a < 13) return m_stall[a-8] * 128 + m_ack[a-8] * 16 + m_mode[a-8];
        if (a == 15) return m_pend;
        return 0;
    endfunction

    task automatic check(string tag, int got, int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) begin
                m_cnt[i] = 0; m_dv[i] = 0; m_tog[i] = 0;
                m_mode[i] = 0; m_ack[i] = 0; m_stall[i] = 0;
            end
            m_pend = 0; m_lock = 0; m_err = 0;
        end else begin
            int  e, a, c, w;
            bit  ev, rx, blocked;
            e  = int'(sie_ep);
            a  = int'(cpu_addr);
            ev = sie_evt && e < 5;
            rx = ev && (sie_tok == 0 || sie_tok == 2);
            m_err = 0;
            // CPU write to a counter (R4, R5, R6)
            if (cpu_wr && a < 5) begin
                blocked = (rx && e == a) || (a == 0 && m_lock != 0);
                if (!blocked) begin
                    c = int'(cpu_wdata[5:0]);
                    if (c > 32) begin c = 32; m_err = 1; end
                    m_cnt[a] = c; m_dv[a] = cpu_wdata[6]; m_tog[a] = cpu_wdata[7];
                end
            end
            // CPU write to a mode register (R6, R7)
            if (cpu_wr && a >= 8 && a < 13 && !(ev && sie_ack && e == a - 8)) begin
                m_mode[a-8] = int'(cpu_wdata[3:0]);
                m_ack[a-8] = cpu_wdata[4];
                m_stall[a-8] = cpu_wdata[7];
            end
            if (cpu_wr && a == 15) m_pend = m_pend & ~int'(cpu_wdata[4:0]);
            if (cpu_rd && a == 0) m_lock = 0;
            if (rx) begin
                c = int'(sie_cnt);
                if (c > 34) begin c = 34; m_err = 1; end
                m_cnt[e] = c; m_dv[e] = sie_crc_ok; m_tog[e] = sie_tog;
                if (e == 0) m_lock = 1;
            end
            if (ev && sie_ack) m_ack[e] = 1;
            if (ev) m_pend = m_pend | (1 << e);
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            int exp_so, exp_si, a;
            string tg;
            exp_so = 0; exp_si = 0;
            for (int i = 0; i < 5; i++) begin
                if (m_stall[i] != 0 && m_mode[i] == 13) exp_so |= (1 << i);
                if (m_stall[i] != 0 && m_mode[i] == 9)  exp_si |= (1 << i);
            end
            a = int'(cpu_addr);
            tg = (a < 5) ? "R2" : (a >= 8 && a < 13) ? "R7" : (a == 15) ? "R8" : "R1";
            check("R8 ep_irq", int'(ep_irq), m_pend);
            check("R9 stall_out", int'(ep_stall_out), exp_so);
            check("R9 stall_in", int'(ep_stall_in), exp_si);
            check("R3 cnt_err", int'(cnt_err), m_err);
            check({tg, " rdata"}, int'(cpu_rdata), m_read(a));
        end
    end

    task automatic cyc(bit wr, bit rd, int addr, int wd, bit ev, int ep, int tok,
                       int cnt, bit crc, bit tog, bit ack);
        @(negedge clk); #1;
        cpu_wr = wr; cpu_rd = rd; cpu_addr = 4'(addr); cpu_wdata = 8'(wd);
        sie_evt = ev; sie_ep = 3'(ep); sie_tok = 2'(tok); sie_cnt = 7'(cnt);
        sie_crc_ok = crc; sie_tog = tog; sie_ack = ack;
    endtask

    task automatic wr(int a, int d);  cyc(1, 0, a, d, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic rdq(int a);        cyc(0, 1, a, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic ev(int ep, int tok, int cnt, bit crc, bit tog, bit ack);
        cyc(0, 0, 0, 0, 1, ep, tok, cnt, crc, tog, ack);
    endtask

    task automatic peek(string tag, int a, int exp);
        cyc(0, 0, a, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        check(tag, int'(cpu_rdata), exp);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        peek("R1 pending after reset", 15, 0);
        peek("R1 counter after reset", 0, 0);
        // R4: plain counter write
        wr(1, 8'h94);
        peek("R4 ep1 counter", 1, 8'h94);
        // R3: CPU count above 32 saturates
        wr(2, 8'h3F);
        @(negedge clk);
        check("R3 cpu saturate err", int'(cnt_err), 1);
        peek("R3 ep2 count", 2, 8'h20);
        // R2 and R5: OUT on ep0 loads and locks
        ev(0, 0, 10, 1, 1, 1);
        peek("R2 ep0 after OUT", 0, 8'hCA);
        wr(0, 8'h05);
        peek("R5 locked write ignored", 0, 8'hCA);
        rdq(0);
        wr(0, 8'h05);
        peek("R5 write after unlock", 0, 8'h05);
        // R3 and R8: bad-CRC SETUP with oversized count
        ev(0, 2, 50, 0, 0, 0);
        @(negedge clk);
        check("R3 sie saturate err", int'(cnt_err), 1);
        check("R8 irq on bad crc", int'(ep_irq[0]), 1);
        peek("R2 ep0 dv clear", 0, 8'h22);
        // R5: unlock read coincident with a new update keeps the lock
        cyc(0, 1, 0, 0, 1, 0, 0, 4, 1, 0, 0);
        wr(0, 8'h01);
        peek("R5 lock kept", 0, 8'h44);
        rdq(0);
        // R6: event beats CPU write on ep3; R5: ep3 never locks
        cyc(1, 0, 3, 8'h10, 1, 3, 0, 6, 1, 0, 0);
        peek("R6 event wins counter", 3, 8'h46);
        wr(3, 8'h10);
        peek("R5 ep3 unlocked", 3, 8'h10);
        // R7 and R9: mode writes
        wr(9, 8'hFD);
        peek("R7 reserved dropped", 9, 8'h9D);
        check("R9 stall_out", int'(ep_stall_out), 5'b00010);
        wr(9, 8'h89);
        peek("R9 mode ack-out", 9, 8'h89);
        check("R9 stall_in", int'(ep_stall_in), 5'b00010);
        // R6: ACK set beats mode write; R2: IN leaves counter
        cyc(1, 0, 9, 0, 1, 1, 1, 20, 1, 1, 1);
        peek("R6 ack wins mode", 9, 8'h99);
        peek("R2 IN keeps counter", 1, 8'h94);
        // R8: clear and set together
        cyc(1, 0, 15, 8'h1F, 1, 4, 1, 0, 0, 0, 0);
        peek("R8 set wins clear", 15, 8'h10);
        // R10: out-of-range endpoint
        ev(6, 0, 9, 1, 1, 1);
        peek("R10 pending unchanged", 15, 8'h10);
        peek("R10 ep0 unchanged", 0, 8'h44);
        // random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            cyc(($urandom % 4) == 0, ($urandom % 5) == 0, int'($urandom % 16),
                int'($urandom % 256), ($urandom % 3) == 0, int'($urandom % 7),
                int'($urandom % 4), int'($urandom % 48), $urandom % 2,
                $urandom % 2, $urandom % 2);
        end
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule